// File: doc/BRIEF.md
# Mesh Control-Flit Bypass Stop

This block is one input-port slice of a light side network laid over a 2D-mesh router. Only single-flit control packets use the side network. Each flit that arrives on the mesh link is sorted by a marker bit:

- A data flit goes straight to the normal router input.
- A control flit is routed by dimension-ordered (X then Y) rules, and goes to one of three places:
  - If it keeps travelling in the same dimension, it is registered once and driven onto the outgoing link on the next cycle. It never enters the router pipeline.
  - If it has reached its column on a horizontal port and must turn, it is written into a two-entry turn buffer. The normal router pipeline drains that buffer.
  - If it has reached its destination node, it is handed to the local ejection output in the cycle it arrives.

The stop owns the outgoing link whenever its bypass buffer sends. It raises a claim signal in that cycle so the router withholds its own flit, and the stop's output mux passes the router's flit only when the bypass is idle. Flow control is credit based in both directions:

- Toward the downstream stop, a counter holds the number of free downstream bypass slots. When that count is zero, flits wait in the local bypass buffer.
- Toward the upstream neighbour, the stop reports each cycle how many of its control slots were freed.

The node's own coordinates are inputs. The port orientation is a parameter: on a vertical port the turn buffer is absent.

Top module: `ctrl_bypass_stop`

## Requirements
- R1: A flit whose top bit (bit FLIT_W-1) is 0 is a data flit. It appears unchanged on `data_vld`/`data_flit` in the same cycle, and it produces no ejection, no credit return and no link output.
- R2: A control flit (top bit 1) whose destination X (bits [2:0]) differs from `my_x` is pushed into the bypass buffer. If that buffer was empty and a downstream credit is held, the flit is on `lnk_vld`/`lnk_flit` in the cycle after it arrives and is sent at the next edge.
- R3: A control flit with destination X equal to `my_x` and destination Y (bits [5:3]) not equal to `my_y` enters the turn buffer. It is offered on `turn_vld`/`turn_flit` from the next cycle. It is held stable until `turn_rdy` is high.
- R4: A control flit with destination X and Y both equal to the local coordinates is offered on `eject_vld`/`eject_flit` in the same cycle and is not buffered.
- R5: The turn buffer holds two flits and releases them in arrival order.
- R6: `link_busy` is high exactly in the cycles when the bypass buffer sends a flit on the link. In those cycles `lnk_flit` is that flit. In all other cycles `lnk_vld`/`lnk_flit` follow `rtr_vld`/`rtr_flit`.
- R7: The downstream credit count starts at DN_CREDITS (2 by default). Each sent flit uses one credit and each `dn_crd` pulse returns one. At zero credits nothing is sent, and held flits then leave in arrival order as credits return.
- R8: Control flits leave the stop bit-identical. In particular, the message-class/virtual-channel field (bits [7:6]) is never rewritten, including at a turn.
- R9: `up_crd_ret` equals the number of control slots freed in the current cycle: one for a bypass send, one for a turn-buffer hand-off and one for an ejection. The value ranges from 0 to 3.
- R10: After reset, `lnk_vld`, `link_busy`, `turn_vld`, `eject_vld` and `up_crd_ret` are all low or zero, and the full downstream credit count is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | X_W | Local node X coordinate |
| my_y | input | Y_W | Local node Y coordinate |
| in_vld | input | 1 | Incoming link flit valid |
| in_flit | input | FLIT_W | Incoming link flit |
| data_vld | output | 1 | Data flit to router input valid |
| data_flit | output | FLIT_W | Data flit to router input |
| eject_vld | output | 1 | Control flit for local node valid |
| eject_flit | output | FLIT_W | Control flit for local node |
| turn_vld | output | 1 | Turn-buffer head valid |
| turn_flit | output | FLIT_W | Turn-buffer head flit |
| turn_rdy | input | 1 | Router accepts turn-buffer head |
| rtr_vld | input | 1 | Router flit for the outgoing link valid |
| rtr_flit | input | FLIT_W | Router flit for the outgoing link |
| dn_crd | input | 1 | One downstream bypass credit returned |
| lnk_vld | output | 1 | Outgoing link flit valid |
| lnk_flit | output | FLIT_W | Outgoing link flit |
| link_busy | output | 1 | Bypass owns the outgoing link this cycle |
| up_crd_ret | output | 2 | Control slots freed this cycle, returned upstream |

## Verification
Each internal fault shows up quickly at the ports:

- A wrong route decision is visible within one cycle. The flit surfaces on the wrong one of the eject, turn or link outputs, or on none of them.
- A corrupted bypass or turn pointer swaps or repeats flits. This appears on the first read after the fault.
- A credit counter that drifts either sends a flit while the bench has withheld credits, or stalls a held flit after a credit has been returned. Both show within one or two cycles of the credit event.
- A wrong claim decision shows in the same cycle as a router flit leaking onto the link, or as `link_busy` disagreeing with the link contents.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [1:0] {
    RT_DATA  = 2'd0,
    RT_PASS  = 2'd1,
    RT_TURN  = 2'd2,
    RT_EJECT = 2'd3
  } route_e;
endpackage

// File: rtl/cbs_route.sv
module cbs_route
  import cbs_pkg::*;
#(
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  parameter bit HORIZ = 1'b1
) (
  input  logic           vld,
  input  logic           is_ctrl,
  input  logic [X_W-1:0] dst_x,
  input  logic [Y_W-1:0] dst_y,
  input  logic [X_W-1:0] my_x,
  input  logic [Y_W-1:0] my_y,
  output route_e         route
);
  logic x_hit;
  logic y_hit;

  assign x_hit = (dst_x == my_x);
  assign y_hit = (dst_y == my_y);

  generate
    if (HORIZ) begin : g_horiz
      always_comb begin
        route = RT_DATA;
        if (vld && is_ctrl) begin
          if (!x_hit)      route = RT_PASS;
          else if (!y_hit) route = RT_TURN;
          else             route = RT_EJECT;
        end
      end
    end else begin : g_vert
      logic unused_x;
      assign unused_x = x_hit;
      always_comb begin
        route = RT_DATA;
        if (vld && is_ctrl) begin
          if (!y_hit) route = RT_PASS;
          else        route = RT_EJECT;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cbs_fifo.sv
module cbs_fifo #(
  parameter int W     = 128,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         vld,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = nxt(wr_q);
    if (pop)  rd_d = nxt(rd_q);
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout = mem[rd_q];
  assign vld  = (cnt_q != '0);
  assign full = (cnt_q == CW'(DEPTH));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> vld);
endmodule

// File: rtl/cbs_credit.sv
module cbs_credit #(
  parameter int MAX = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic give,
  input  logic take,
  output logic avail
);
  localparam int CW = $clog2(MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (give && !take)      cnt_d = cnt_q + 1'b1;
    else if (take && !give) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(MAX);
    else        cnt_q <= cnt_d;
  end

  assign avail = (cnt_q != '0);

  // R7
  crd_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    give |-> (cnt_q != CW'(MAX) || take));
endmodule

// File: rtl/ctrl_bypass_stop.sv
module ctrl_bypass_stop
  import cbs_pkg::*;
#(
  parameter int FLIT_W     = 128,
  parameter int X_W        = 3,
  parameter int Y_W        = 3,
  parameter int CLS_W      = 2,
  parameter int BYP_DEPTH  = 2,
  parameter int TURN_DEPTH = 2,
  parameter int DN_CREDITS = 2,
  parameter bit HORIZ      = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [X_W-1:0]    my_x,
  input  logic [Y_W-1:0]    my_y,
  input  logic              in_vld,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              data_vld,
  output logic [FLIT_W-1:0] data_flit,
  output logic              eject_vld,
  output logic [FLIT_W-1:0] eject_flit,
  output logic              turn_vld,
  output logic [FLIT_W-1:0] turn_flit,
  input  logic              turn_rdy,
  input  logic              rtr_vld,
  input  logic [FLIT_W-1:0] rtr_flit,
  input  logic              dn_crd,
  output logic              lnk_vld,
  output logic [FLIT_W-1:0] lnk_flit,
  output logic              link_busy,
  output logic [1:0]        up_crd_ret
);
  localparam int CTRL_BIT = FLIT_W - 1;
  localparam int Y_LO     = X_W;
  localparam int CLS_LO   = X_W + Y_W;

  route_e            route;
  logic              byp_push, byp_pop, byp_vld, byp_full;
  logic [FLIT_W-1:0] byp_dout;
  logic              crd_avail;
  logic              turn_pop;

  cbs_route #(.X_W(X_W), .Y_W(Y_W), .HORIZ(HORIZ)) route_i (
    .vld     (in_vld),
    .is_ctrl (in_flit[CTRL_BIT]),
    .dst_x   (in_flit[X_W-1:0]),
    .dst_y   (in_flit[Y_LO +: Y_W]),
    .my_x    (my_x),
    .my_y    (my_y),
    .route   (route)
  );

  // input demultiplexer
  assign data_vld   = in_vld && !in_flit[CTRL_BIT];
  assign data_flit  = in_flit;
  assign eject_vld  = (route == RT_EJECT);
  assign eject_flit = in_flit;

  // one-cycle forwarding path
  assign byp_push = (route == RT_PASS);
  assign byp_pop  = byp_vld && crd_avail;

  cbs_fifo #(.W(FLIT_W), .DEPTH(BYP_DEPTH)) byp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (byp_push),
    .din   (in_flit),
    .pop   (byp_pop),
    .dout  (byp_dout),
    .vld   (byp_vld),
    .full  (byp_full)
  );

  cbs_credit #(.MAX(DN_CREDITS)) crd_i (
    .clk   (clk),
    .rst_n (rst_n),
    .give  (dn_crd),
    .take  (byp_pop),
    .avail (crd_avail)
  );

  // link claim and output mux
  assign link_busy = byp_pop;
  assign lnk_vld   = link_busy || rtr_vld;
  assign lnk_flit  = link_busy ? byp_dout : rtr_flit;

  generate
    if (HORIZ) begin : g_turn
      logic turn_push, turn_full;
      assign turn_push = (route == RT_TURN);
      assign turn_pop  = turn_vld && turn_rdy;

      cbs_fifo #(.W(FLIT_W), .DEPTH(TURN_DEPTH)) turn_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (turn_push),
        .din   (in_flit),
        .pop   (turn_pop),
        .dout  (turn_flit),
        .vld   (turn_vld),
        .full  (turn_full)
      );

      // R3
      turn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_vld && !turn_rdy) |=> (turn_vld && $stable(turn_flit)));
    end else begin : g_noturn
      logic unused_rdy;
      assign unused_rdy = turn_rdy;
      assign turn_vld   = 1'b0;
      assign turn_flit  = '0;
      assign turn_pop   = 1'b0;
    end
  endgenerate

  assign up_crd_ret = {1'b0, byp_pop} + {1'b0, turn_pop} + {1'b0, eject_vld};

  logic unused_full;
  assign unused_full = byp_full;

  // R6
  claim_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_busy |-> (lnk_vld && lnk_flit[CTRL_BIT]));
  // R6
  rtr_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_busy |-> !rtr_vld);
  // R1
  data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld |-> (!eject_vld && !in_flit[CTRL_BIT]));
  // R8
  cls_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eject_vld |-> (eject_flit[CLS_LO +: CLS_W] == in_flit[CLS_LO +: CLS_W]));
endmodule

// File: tb/ctrl_bypass_stop_tb.sv
module ctrl_bypass_stop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 128;

  logic          clk, rst_n;
  logic [2:0]    my_x, my_y;
  logic          in_vld, turn_rdy, rtr_vld, dn_crd;
  logic [FW-1:0] in_flit, rtr_flit;
  logic          data_vld, eject_vld, turn_vld, lnk_vld, link_busy;
  logic [FW-1:0] data_flit, eject_flit, turn_flit, lnk_flit;
  logic [1:0]    up_crd_ret;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  ctrl_bypass_stop dut_i (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_vld(in_vld), .in_flit(in_flit),
    .data_vld(data_vld), .data_flit(data_flit),
    .eject_vld(eject_vld), .eject_flit(eject_flit),
    .turn_vld(turn_vld), .turn_flit(turn_flit), .turn_rdy(turn_rdy),
    .rtr_vld(rtr_vld), .rtr_flit(rtr_flit), .dn_crd(dn_crd),
    .lnk_vld(lnk_vld), .lnk_flit(lnk_flit), .link_busy(link_busy),
    .up_crd_ret(up_crd_ret)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [FW-1:0] mk(input bit c, input int x, input int y,
                                       input int cls, input logic [31:0] pay);
    logic [FW-1:0] f;
    f = {4{pay}};
    f[2:0] = 3'(x);
    f[5:3] = 3'(y);
    f[7:6] = 2'(cls);
    f[FW-1] = c;
    return f;
  endfunction

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic idle_check(input string req);
    chk(req, FW'(lnk_vld), 1);
    chk(req, FW'(turn_vld), 0);
  endtask

  initial begin
    logic [FW-1:0] f1, f2, f3, f4;
    rst_n = 0; my_x = 3'd3; my_y = 3'd4;
    in_vld = 0; in_flit = '0; turn_rdy = 1; rtr_vld = 0; rtr_flit = '0; dn_crd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 lnk_vld", FW'(lnk_vld), 0);
    chk("R10 link_busy", FW'(link_busy), 0);
    chk("R10 turn_vld", FW'(turn_vld), 0);
    chk("R10 eject_vld", FW'(eject_vld), 0);
    chk("R10 up_crd_ret", FW'(up_crd_ret), 0);

    // R2 R3 R4 R8 R9: sweep over all destinations
    for (int x = 0; x < 8; x++) begin
      for (int y = 0; y < 8; y++) begin
        logic [FW-1:0] f;
        bit ej, ps, tn;
        f  = mk(1, x, y, (x + y) % 4, 32'h5a00 + 32'(x * 8 + y));
        ej = (x == 3) && (y == 4);
        ps = (x != 3);
        tn = (x == 3) && (y != 4);
        in_vld = 1; in_flit = f;
        #1;
        chk("R4 eject_vld", FW'(eject_vld), FW'(ej));
        if (ej) chk("R4 R8 eject_flit", eject_flit, f);
        chk("R1 data_vld ctrl", FW'(data_vld), 0);
        chk("R9 crd arrival", FW'(up_crd_ret), FW'(ej));
        @(negedge clk);
        in_vld = 0; dn_crd = ps;
        #1;
        chk("R2 lnk_vld", FW'(lnk_vld), FW'(ps));
        chk("R6 link_busy", FW'(link_busy), FW'(ps));
        if (ps) chk("R2 R8 lnk_flit", lnk_flit, f);
        chk("R3 turn_vld", FW'(turn_vld), FW'(tn));
        if (tn) chk("R3 R8 turn_flit", turn_flit, f);
        chk("R9 crd leave", FW'(up_crd_ret), FW'(ps || tn));
        @(negedge clk);
        dn_crd = 0;
        #1;
        chk("R2 drained lnk", FW'(lnk_vld), 0);
        chk("R3 drained turn", FW'(turn_vld), 0);
      end
    end

    // R1 data flits
    for (int k = 0; k < 6; k++) begin
      logic [FW-1:0] d;
      d = mk(0, k, 7 - k, k % 4, 32'hd0d0_0000 + 32'(k));
      @(negedge clk);
      in_vld = 1; in_flit = d;
      #1;
      chk("R1 data_vld", FW'(data_vld), 1);
      chk("R1 data_flit", data_flit, d);
      chk("R1 no eject", FW'(eject_vld), 0);
      chk("R1 no credit", FW'(up_crd_ret), 0);
      @(negedge clk);
      in_vld = 0;
      #1;
      chk("R1 no link", FW'(lnk_vld), 0);
      chk("R1 no turn", FW'(turn_vld), 0);
    end

    // R6 router passthrough while bypass idle
    @(negedge clk);
    f1 = mk(0, 1, 1, 2, 32'hcafe_0001);
    rtr_vld = 1; rtr_flit = f1;
    #1;
    chk("R6 rtr lnk_vld", FW'(lnk_vld), 1);
    chk("R6 rtr lnk_flit", lnk_flit, f1);
    chk("R6 rtr not busy", FW'(link_busy), 0);
    @(negedge clk);
    rtr_vld = 0;

    // R7 R10 credit backpressure, full initial credits
    f1 = mk(1, 0, 2, 1, 32'hb001);
    f2 = mk(1, 5, 6, 2, 32'hb002);
    f3 = mk(1, 7, 0, 3, 32'hb003);
    f4 = mk(1, 1, 4, 0, 32'hb004);
    in_vld = 1; in_flit = f1;
    @(negedge clk); in_flit = f2; #1;
    chk("R7 R10 first", lnk_flit, f1);
    @(negedge clk); in_flit = f3; #1;
    chk("R7 R10 second", lnk_flit, f2);
    @(negedge clk); in_flit = f4; #1;
    chk("R7 stall", FW'(lnk_vld), 0);
    @(negedge clk); in_vld = 0; #1;
    chk("R7 stall2", FW'(lnk_vld), 0);
    dn_crd = 1;
    @(negedge clk); dn_crd = 0; #1;
    chk("R7 release f3 vld", FW'(lnk_vld), 1);
    chk("R7 release f3", lnk_flit, f3);
    @(negedge clk); #1;
    chk("R7 stall3", FW'(lnk_vld), 0);
    dn_crd = 1;
    @(negedge clk); dn_crd = 0; #1;
    chk("R7 release f4", lnk_flit, f4);
    @(negedge clk); dn_crd = 1;
    @(negedge clk); dn_crd = 1;
    @(negedge clk); dn_crd = 0;

    // R5 R3 turn order and hold
    f1 = mk(1, 3, 0, 2, 32'h7001);
    f2 = mk(1, 3, 7, 1, 32'h7002);
    turn_rdy = 0;
    in_vld = 1; in_flit = f1;
    @(negedge clk); in_flit = f2;
    @(negedge clk); in_vld = 0; #1;
    chk("R5 head first", turn_flit, f1);
    @(negedge clk); #1;
    chk("R3 hold vld", FW'(turn_vld), 1);
    chk("R3 hold flit", turn_flit, f1);
    turn_rdy = 1; #1;
    chk("R9 turn pop", FW'(up_crd_ret), 1);
    @(negedge clk); #1;
    chk("R5 second", turn_flit, f2);
    @(negedge clk); #1;
    chk("R5 empty", FW'(turn_vld), 0);

    // R9 two slots freed in one cycle
    turn_rdy = 0;
    in_vld = 1; in_flit = mk(1, 3, 1, 3, 32'h9001);
    @(negedge clk); in_vld = 0;
    @(negedge clk);
    in_vld = 1; in_flit = mk(1, 3, 4, 0, 32'h9002); turn_rdy = 1; #1;
    chk("R9 dual free", FW'(up_crd_ret), 2);
    @(negedge clk); in_vld = 0; #1;
    chk("R9 after", FW'(turn_vld), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule